// File: doc/BRIEF.md
# SCL Stall and Bus-Idle Timeout Watch

This block supervises a two-wire serial bus for two kinds of stall, counting ticks of an already prescaled bus clock. The first stall is a bus that the controller still believes is busy while SCL has sat high with no edge for too long; this typically means a STOP was lost. The second stall is SCL held low for too long by some device on the bus. Each stall has its own coded threshold select, its own sticky flag, and its own pair of write-one set and clear strobes.

An idle stall can also ask the bus state machine to drop back to its idle state. When the go-idle enable is set, the block emits a single-cycle force-idle pulse at the moment the idle stall is detected. A flag fires once per stall: its counter saturates at the threshold and only starts over when the stall condition is broken.

Top module: `scl_timeout_watch`

## Requirements
- R1: During and right after synchronous active-low reset, both flags and the force-idle pulse are 0.
- R2: The idle threshold select codes mean 0 = disabled, 1 = 40, 2 = 80, 3 = 160 prescaled ticks.
- R3: The idle counter advances on a tick only while busy is 1 and SCL is high with no SCL change since the previous clock; busy low, SCL low or any SCL edge returns it to zero.
- R4: The low threshold select codes mean 0 = disabled, 1 = 40, 2 = 80, 3 = 160, 4 = 320, 5 = 1024 prescaled ticks; codes 6 and 7 are disabled.
- R5: The low counter advances on a tick while SCL is low and returns to zero whenever SCL is high.
- R6: A flag is set once, when its counter reaches the threshold; the counter then holds and causes no further set until its condition is broken.
- R7: The force-idle output is a one-cycle pulse, raised only when the idle stall is detected and go-idle enable is 1; a low stall never raises it.
- R8: A set strobe raises its flag and a clear strobe lowers it on the next clock; when set and clear arrive together, the flag ends set.
- R9: A flag stays set until its clear strobe arrives.
- R10: A flag and the force-idle pulse become visible in the cycle after the clock edge that samples the qualifying tick which brings the count to the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle prescaled tick |
| scl | input | 1 | Synchronised SCL level |
| bus_busy | input | 1 | Bus considered busy by the bus state machine |
| idle_sel | input | 2 | Idle threshold select (R2 codes) |
| low_sel | input | 3 | Low threshold select (R4 codes) |
| go_idle_en | input | 1 | Enables the force-idle pulse on idle stall |
| idle_set | input | 1 | Write-one set of the idle flag |
| idle_clr | input | 1 | Write-one clear of the idle flag |
| low_set | input | 1 | Write-one set of the low flag |
| low_clr | input | 1 | Write-one clear of the low flag |
| idle_flag | output | 1 | Sticky idle stall flag |
| low_flag | output | 1 | Sticky SCL-low stall flag |
| force_idle | output | 1 | One-cycle request to return the bus state to idle |

## Verification
A counter that restarts wrongly or misses a restart shows as a flag rising early, late or never, and the error is visible in the exact cycle the flag should have changed, at most 1024 ticks after the stall starts. A counter that does not saturate shows as a second flag set after a clear, or a second force-idle pulse, inside the same unbroken stall. Wrong strobe priority shows on the flag one cycle after the strobe. The bench runs a cycle-level model of the requirements next to the design and compares all three outputs on every cycle.

// File: rtl/scl_tmo_pkg.sv
// Shared constants and threshold decode for the SCL timeout watch.
// Assumes: thresholds are whole multiples of a base count, except the
// longest low threshold, which is given on its own.
package scl_tmo_pkg;

    // Smallest threshold, in prescaled ticks
    localparam int unsigned TMO_BASE = 40;
    // Longest low threshold, in prescaled ticks
    localparam int unsigned TMO_LONG = 1024;

    // Which of the two watchers a decoder serves
    typedef enum logic {
        WATCH_IDLE = 1'b0,
        WATCH_LOW  = 1'b1
    } watch_kind_e;

endpackage

// File: rtl/scl_tmo_limit.sv
// Threshold decoder: turns a select code into a tick count limit.
// A limit of zero means the watcher is disabled.
// Assumes: codes 1..4 double the base count each step; on the low
// watcher, code 5 gives LONG and any code above 5 disables.
module scl_tmo_limit #(
    parameter scl_tmo_pkg::watch_kind_e KIND = scl_tmo_pkg::WATCH_IDLE,
    parameter int unsigned SEL_W = 2,
    parameter int unsigned CNT_W = 11,
    parameter int unsigned BASE  = 40,
    parameter int unsigned LONG  = 1024
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] limit
);
    localparam logic [CNT_W-1:0] BASE_C = CNT_W'(BASE);
    localparam logic [CNT_W-1:0] LONG_C = CNT_W'(LONG);

    generate
        if (KIND == scl_tmo_pkg::WATCH_IDLE) begin : g_idle
            // Idle decode: 0 off, then base doubled per step
            always_comb begin
                if (sel == '0) begin
                    limit = '0;
                end else begin
                    limit = BASE_C << (sel - SEL_W'(1));
                end
            end
        end else begin : g_low
            // Low decode: 0 off, 1..4 doubled base, 5 long, rest off
            always_comb begin
                unique case (int'(sel))
                    1, 2, 3, 4: limit = BASE_C << (sel - SEL_W'(1));
                    5:          limit = LONG_C;
                    default:    limit = '0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/scl_tmo_count.sv
// Saturating stall counter. Counts ticks while running, returns to zero
// on restart or when disabled, and holds once the limit is reached.
// hit is high for the one clock whose tick brings the count to limit.
// Assumes: limit may change at any time; a count above a new limit holds.
module scl_tmo_count #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;
    logic             enabled;
    logic             below;

    assign enabled = (limit != '0);
    assign below   = (cnt < limit);

    // Count qualifying ticks, clear on restart or disable, hold at limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !enabled) begin
            cnt <= '0;
        end else if (tick && below) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Report the single tick that reaches the limit
    always_comb begin
        hit = enabled && !restart && tick && (cnt == (limit - CNT_W'(1)));
    end

endmodule

// File: rtl/scl_tmo_flag.sv
// Sticky event flag with write-one set and clear strobes.
// Assumes: set and hardware hit both win over clear in the same cycle.
module scl_tmo_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic set_s,
    input  logic clr_s,
    output logic flag
);
    // Hold the flag; set sources win over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit || set_s) begin
            flag <= 1'b1;
        end else if (clr_s) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/scl_timeout_watch.sv
// SCL timeout watch: two stall detectors (bus idle with SCL high, and
// SCL held low) on a prescaled tick, each with sticky flag and strobes,
// plus a one-cycle force-idle request on idle stall.
// Assumes: scl is already synchronised; tick is a one-cycle pulse.
module scl_timeout_watch #(
    parameter int unsigned IDLE_SEL_W = 2,
    parameter int unsigned LOW_SEL_W  = 3,
    parameter int unsigned BASE_TICKS = scl_tmo_pkg::TMO_BASE,
    parameter int unsigned LONG_TICKS = scl_tmo_pkg::TMO_LONG
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  scl,
    input  logic                  bus_busy,
    input  logic [IDLE_SEL_W-1:0] idle_sel,
    input  logic [LOW_SEL_W-1:0]  low_sel,
    input  logic                  go_idle_en,
    input  logic                  idle_set,
    input  logic                  idle_clr,
    input  logic                  low_set,
    input  logic                  low_clr,
    output logic                  idle_flag,
    output logic                  low_flag,
    output logic                  force_idle
);
    localparam int unsigned MAX_SHIFTED = BASE_TICKS << ((1 << IDLE_SEL_W) - 2);
    localparam int unsigned MAX_LIMIT   = (MAX_SHIFTED > LONG_TICKS) ? MAX_SHIFTED
                                        : ((BASE_TICKS << 3) > LONG_TICKS ? (BASE_TICKS << 3)
                                                                          : LONG_TICKS);
    localparam int unsigned CNT_W       = $clog2(MAX_LIMIT + 1);

    logic             scl_q;
    logic             scl_edge;
    logic             idle_restart;
    logic             low_restart;
    logic [CNT_W-1:0] idle_limit;
    logic [CNT_W-1:0] low_limit;
    logic             idle_hit;
    logic             low_hit;

    // Remember last SCL level to spot edges; bus rests high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
        end else begin
            scl_q <= scl;
        end
    end

    // Restart conditions for each watcher
    always_comb begin
        scl_edge     = (scl != scl_q);
        idle_restart = !(bus_busy && scl) || scl_edge;
        low_restart  = scl;
    end

    scl_tmo_limit #(
        .KIND  (scl_tmo_pkg::WATCH_IDLE),
        .SEL_W (IDLE_SEL_W),
        .CNT_W (CNT_W),
        .BASE  (BASE_TICKS),
        .LONG  (LONG_TICKS)
    ) u_idle_limit (
        .sel   (idle_sel),
        .limit (idle_limit)
    );

    scl_tmo_limit #(
        .KIND  (scl_tmo_pkg::WATCH_LOW),
        .SEL_W (LOW_SEL_W),
        .CNT_W (CNT_W),
        .BASE  (BASE_TICKS),
        .LONG  (LONG_TICKS)
    ) u_low_limit (
        .sel   (low_sel),
        .limit (low_limit)
    );

    scl_tmo_count #(.CNT_W(CNT_W)) u_idle_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (idle_restart),
        .limit   (idle_limit),
        .hit     (idle_hit)
    );

    scl_tmo_count #(.CNT_W(CNT_W)) u_low_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (low_restart),
        .limit   (low_limit),
        .hit     (low_hit)
    );

    scl_tmo_flag u_idle_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (idle_hit),
        .set_s (idle_set),
        .clr_s (idle_clr),
        .flag  (idle_flag)
    );

    scl_tmo_flag u_low_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (low_hit),
        .set_s (low_set),
        .clr_s (low_clr),
        .flag  (low_flag)
    );

    // Single-cycle request to send the bus state machine to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_idle <= 1'b0;
        end else begin
            force_idle <= idle_hit && go_idle_en;
        end
    end

endmodule

// File: rtl/scl_timeout_watch_chk.sv
// Port-level properties of the SCL timeout watch, bound to the top.
module scl_timeout_watch_chk #(
    parameter int unsigned IDLE_SEL_W = 2,
    parameter int unsigned LOW_SEL_W  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl,
    input logic                  bus_busy,
    input logic [IDLE_SEL_W-1:0] idle_sel,
    input logic [LOW_SEL_W-1:0]  low_sel,
    input logic                  go_idle_en,
    input logic                  idle_set,
    input logic                  idle_clr,
    input logic                  low_set,
    input logic                  low_clr,
    input logic                  idle_flag,
    input logic                  low_flag,
    input logic                  force_idle
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!idle_flag && !low_flag && !force_idle));

    // R7
    force_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle |=> !force_idle);

    // R7
    force_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_idle) |-> ($past(go_idle_en) && idle_flag));

    // R8
    idle_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_set |=> idle_flag);

    // R8
    low_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_set |=> low_flag);

    // R9
    idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !idle_clr) |=> idle_flag);

    // R9
    low_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_flag && !low_clr) |=> low_flag);

    // R3
    idle_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> ($past(idle_set) || ($past(bus_busy) && $past(scl)
                               && $past(idle_sel) != '0)));

    // R5
    low_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_flag) |-> ($past(low_set) || !$past(scl)));

    // R4
    low_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(low_flag) && ($past(low_sel) == '0 || $past(low_sel) > LOW_SEL_W'(5)))
            |-> $past(low_set));

endmodule

bind scl_timeout_watch scl_timeout_watch_chk #(
    .IDLE_SEL_W (IDLE_SEL_W),
    .LOW_SEL_W  (LOW_SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl        (scl),
    .bus_busy   (bus_busy),
    .idle_sel   (idle_sel),
    .low_sel    (low_sel),
    .go_idle_en (go_idle_en),
    .idle_set   (idle_set),
    .idle_clr   (idle_clr),
    .low_set    (low_set),
    .low_clr    (low_clr),
    .idle_flag  (idle_flag),
    .low_flag   (low_flag),
    .force_idle (force_idle)
);

// File: tb/scl_timeout_watch_bench.sv
`timescale 1ns/1ps
module scl_timeout_watch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       scl = 1'b1;
    logic       bus_busy = 1'b0;
    logic [1:0] idle_sel = 2'd0;
    logic [2:0] low_sel = 3'd0;
    logic       go_idle_en = 1'b0;
    logic       idle_set = 1'b0;
    logic       idle_clr = 1'b0;
    logic       low_set = 1'b0;
    logic       low_clr = 1'b0;
    logic       idle_flag;
    logic       low_flag;
    logic       force_idle;

    int checks = 0;
    int failures = 0;

    // requirement model state
    int m_icnt = 0;
    int m_lcnt = 0;
    bit m_prev = 1'b1;
    bit m_iflag = 1'b0;
    bit m_lflag = 1'b0;
    bit m_force = 1'b0;

    always #2.5 clk = ~clk;

    scl_timeout_watch u_scl_timeout_watch (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scl(scl), .bus_busy(bus_busy),
        .idle_sel(idle_sel), .low_sel(low_sel), .go_idle_en(go_idle_en),
        .idle_set(idle_set), .idle_clr(idle_clr), .low_set(low_set),
        .low_clr(low_clr), .idle_flag(idle_flag), .low_flag(low_flag),
        .force_idle(force_idle)
    );

    // thresholds from R2 and R4
    function automatic int idle_thr(input logic [1:0] s);
        case (s)
            2'd1: return 40;
            2'd2: return 80;
            2'd3: return 160;
            default: return 0;
        endcase
    endfunction

    function automatic int low_thr(input logic [2:0] s);
        case (s)
            3'd1: return 40;
            3'd2: return 80;
            3'd3: return 160;
            3'd4: return 320;
            3'd5: return 1024;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: update the model from the sampled inputs, compare at negedge
    task automatic step();
        bit hi;
        bit hl;
        int ith;
        int lth;
        @(posedge clk);
        if (!rst_n) begin
            m_icnt = 0; m_lcnt = 0; m_prev = 1'b1;
            m_iflag = 0; m_lflag = 0; m_force = 0;
        end else begin
            hi = 0; hl = 0;
            ith = idle_thr(idle_sel);
            lth = low_thr(low_sel);
            if (ith == 0 || !(bus_busy && scl) || scl != m_prev) m_icnt = 0;
            else if (tick && m_icnt < ith) begin
                m_icnt++;
                if (m_icnt == ith) hi = 1;
            end
            if (lth == 0 || scl) m_lcnt = 0;
            else if (tick && m_lcnt < lth) begin
                m_lcnt++;
                if (m_lcnt == lth) hl = 1;
            end
            m_iflag = (idle_set || hi) ? 1'b1 : (idle_clr ? 1'b0 : m_iflag);
            m_lflag = (low_set || hl) ? 1'b1 : (low_clr ? 1'b0 : m_lflag);
            m_force = hi && go_idle_en;
            m_prev = scl;
        end
        @(negedge clk);
        check(idle_flag == m_iflag, "R3 R6 R10 model idle_flag", idle_flag, m_iflag);
        check(low_flag == m_lflag, "R5 R6 R10 model low_flag", low_flag, m_lflag);
        check(force_idle == m_force, "R7 model force_idle", force_idle, m_force);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic strobe_clear();
        idle_clr = 1; low_clr = 1; step(); idle_clr = 0; low_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int tcount;
        int dummy;
        dummy = $urandom(32'h5EED_1234);
        steps(3);
        check(!idle_flag && !low_flag && !force_idle, "R1 reset outputs",
              {idle_flag, low_flag, force_idle}, 0);
        @(negedge clk); rst_n = 1;

        // R2 R10: idle 40 ticks, every cycle a tick
        idle_sel = 2'd1; bus_busy = 1; scl = 1; tick = 1; go_idle_en = 1;
        steps(39);
        check(idle_flag == 0, "R10 idle before 40th tick", idle_flag, 0);
        step();
        check(idle_flag == 1, "R2 idle at 40 ticks", idle_flag, 1);
        check(force_idle == 1, "R7 force pulse on idle stall", force_idle, 1);
        step();
        check(force_idle == 0, "R7 force is one cycle", force_idle, 0);

        // R6: clear during saturated stall, no retrigger
        strobe_clear();
        steps(100);
        check(idle_flag == 0, "R6 no retrigger while saturated", idle_flag, 0);

        // R8: set and clear together, set wins
        idle_set = 1; idle_clr = 1; low_set = 1; low_clr = 1; step();
        idle_set = 0; idle_clr = 0; low_set = 0; low_clr = 0;
        check(idle_flag == 1, "R8 idle set beats clear", idle_flag, 1);
        check(low_flag == 1, "R8 low set beats clear", low_flag, 1);
        steps(5);
        check(idle_flag && low_flag, "R9 flags sticky", {idle_flag, low_flag}, 3);

        // R3: SCL edge restarts idle count; 80-tick select; no force when disabled
        strobe_clear();
        idle_sel = 2'd2; go_idle_en = 0;
        scl = 0; step(); scl = 1; step();
        steps(30);
        bus_busy = 0; step(); bus_busy = 1;
        steps(79);
        check(idle_flag == 0, "R3 busy drop restarts count", idle_flag, 0);
        step();
        check(idle_flag == 1, "R2 idle at 80 ticks", idle_flag, 1);
        check(force_idle == 0, "R7 no force without enable", force_idle, 0);

        // R2: select 0 disables idle watch
        strobe_clear();
        idle_sel = 2'd0; scl = 0; step(); scl = 1;
        steps(300);
        check(idle_flag == 0, "R2 idle select 0 off", idle_flag, 0);

        // R4 R5: low watch 1024 ticks
        bus_busy = 0; low_sel = 3'd5; scl = 0;
        steps(1023);
        check(low_flag == 0, "R4 low before 1024 ticks", low_flag, 0);
        step();
        check(low_flag == 1, "R4 low at 1024 ticks", low_flag, 1);
        check(force_idle == 0, "R7 low stall never forces", force_idle, 0);

        // R4: codes 6 and 7 disabled
        strobe_clear(); scl = 1; step(); scl = 0;
        low_sel = 3'd6; steps(1100);
        check(low_flag == 0, "R4 low select 6 off", low_flag, 0);
        low_sel = 3'd7; steps(1100);
        check(low_flag == 0, "R4 low select 7 off", low_flag, 0);

        // R5: half-rate tick, 160-tick threshold, restart when SCL high
        scl = 1; step(); scl = 0; low_sel = 3'd3;
        tcount = 0;
        while (tcount < 159) begin
            tick = ~tick; if (tick) tcount++; step();
        end
        check(low_flag == 0, "R5 low before 160 ticks", low_flag, 0);
        tick = 0; step(); tick = 1; step();
        check(low_flag == 1, "R5 low at 160 ticks", low_flag, 1);

        // random phase against the model
        strobe_clear(); scl = 1; step();
        for (int i = 0; i < 30000; i++) begin
            if (i % 2000 == 0) begin
                idle_sel = 2'($urandom % 4);
                low_sel = 3'($urandom % 8);
                go_idle_en = 1'($urandom % 2);
            end
            tick = ($urandom % 3) != 0;
            if ($urandom % 150 == 0) scl = ~scl;
            if ($urandom % 400 == 0) bus_busy = ~bus_busy;
            idle_set = ($urandom % 500) == 0;
            idle_clr = ($urandom % 300) == 0;
            low_set = ($urandom % 500) == 0;
            low_clr = ($urandom % 300) == 0;
            step();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule